// File: doc/BRIEF.md
# Sticky-Pending Masked Interrupt Controller

This block gathers thirty-two level-sensitive interrupt requests and produces one interrupt line for a processor. Each request passes through a two-stage synchronizer. The synchronized levels are kept in a readable level register. They are also ORed into a sticky pending register on every clock, so a short pulse stays recorded after the request has dropped. A mask register selects which pending bits may raise the processor line. The line is a registered copy of "any pending bit that is also unmasked".

Software uses a small word-addressed register port. It can replace the mask, read the pending bits, and acknowledge them by writing ones (write-one-to-clear). Because the live levels are ORed back in on every clock, an acknowledge of a request that is still held has no effect. For each input a 64-bit counter records how many times the synchronized input has risen. The counters are read through an index register and two data words.

Top module: `irq_pending_ctrl`

## Requirements
- R1: After reset the mask, pending, level, index and all 32 counters read as zero, and `cpu_irq` is low.
- R2: The level register (offset 0x08, read-only) shows `irq_req` delayed by a two-flop synchronizer. Writes to 0x08 are ignored.
- R3: A pending bit (offset 0x04) is set on the clock after its synchronized level is seen high. It stays set until it is acknowledged.
- R4: `cpu_irq` is registered. One clock later it equals the OR of (pending AND mask).
- R5: A write to 0x04 clears each pending bit written as 1 and leaves each bit written as 0 unchanged.
- R6: If a request level is high in the same cycle as an acknowledge of that bit, the bit stays pending.
- R7: A write to 0x00 replaces all 32 mask bits. The new value reads back at 0x00.
- R8: Each input's 64-bit counter increments by exactly one on every rising edge of the synchronized level. It does not change while the level is held high or low.
- R9: The low 5 bits written to 0x0C select a counter. 0x10 reads the low word of the selected counter and 0x14 reads the high word. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 32 | Level-sensitive interrupt requests |
| reg_wr_en | input | 1 | Register write strobe, sampled on the clock edge |
| reg_addr | input | 5 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| cpu_irq | output | 1 | Interrupt line toward the processor |

## Verification
Take a request change on `irq_req` that is first captured at clock edge k. It reaches the level register at edge k+1, the pending bit and the counter at edge k+2, and `cpu_irq` at edge k+3. A mask or acknowledge write at edge k updates its register at k and `cpu_irq` at k+1. The bench keeps a reference model that advances on the same edges. It drives inputs at the falling edge and compares the line and the combinational read data 1 ns later. Every result is therefore checked in exactly the cycle these latencies predict.

// File: rtl/irq_pending_ctrl.sv
module irq_pending_ctrl #(
  parameter int N_SRC  = 32,
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cpu_irq
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(5'h14);

  logic [N_SRC-1:0] sync1, lvl, lvl_d, pend, mask;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt [N_SRC];

  wire              wr_mask = reg_wr_en && reg_addr == A_MASK;
  wire              wr_idx  = reg_wr_en && reg_addr == A_IDX;
  wire [N_SRC-1:0]  ack     = (reg_wr_en && reg_addr == A_PEND) ? reg_wdata[N_SRC-1:0] : '0;
  wire [N_SRC-1:0]  rise    = lvl & ~lvl_d;
  wire [CNT_W-1:0]  sel_cnt = cnt[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      lvl     <= '0;
      lvl_d   <= '0;
      pend    <= '0;
      mask    <= '0;
      idx     <= '0;
      cpu_irq <= 1'b0;
    end else begin
      sync1   <= irq_req;
      lvl     <= sync1;
      lvl_d   <= lvl;
      pend    <= (pend & ~ack) | lvl;
      cpu_irq <= |(pend & mask);
      if (wr_mask) mask <= reg_wdata[N_SRC-1:0];
      if (wr_idx)  idx  <= reg_wdata[IDX_W-1:0];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt[i] <= '0;
      else if (rise[i]) cnt[i] <= cnt[i] + 1'b1;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[i] == lvl_d[i]) |=> $stable(cnt[i]))
      else $error("counter %0d moved without a rising level", i);
  end

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = DATA_W'(mask);
      A_PEND:  reg_rdata = DATA_W'(pend);
      A_LVL:   reg_rdata = DATA_W'(lvl);
      A_IDX:   reg_rdata = DATA_W'(idx);
      A_CLO:   reg_rdata = sel_cnt[DATA_W-1:0];
      A_CHI:   reg_rdata = DATA_W'(sel_cnt[CNT_W-1:DATA_W]);
      default: reg_rdata = '0;
    endcase
  end

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend | $past(ack)) & $past(pend)) == $past(pend))
    else $error("pending bit lost without acknowledge");

  p_level_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend & $past(lvl)) == $past(lvl))
    else $error("high level not pending");

  p_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & mask) == '0 |=> !cpu_irq)
    else $error("line high with nothing unmasked pending");

  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> mask == $past(reg_wdata[N_SRC-1:0]))
    else $error("mask write not taken");

  p_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl == $past(sync1))
    else $error("level register skipped a stage");
endmodule

// File: tb/test_irq_pending_ctrl.sv
module test_irq_pending_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_req = '0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_pending_ctrl i_irq_pending_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq));

  logic [31:0] m_s1, m_lvl, m_lvld, m_pend, m_mask;
  logic [4:0]  m_idx;
  logic        m_irq;
  logic [63:0] m_cnt [32];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_lvl <= '0; m_lvld <= '0; m_pend <= '0;
      m_mask <= '0; m_idx <= '0; m_irq <= 1'b0;
      for (int i = 0; i < 32; i++) m_cnt[i] <= '0;
    end else begin
      m_s1   <= irq_req;
      m_lvl  <= m_s1;
      m_lvld <= m_lvl;
      m_pend <= (m_pend & ~((reg_wr_en && reg_addr == 5'h04) ? reg_wdata : 32'h0)) | m_lvl;
      m_irq  <= (m_pend & m_mask) != 0;
      if (reg_wr_en && reg_addr == 5'h00) m_mask <= reg_wdata;
      if (reg_wr_en && reg_addr == 5'h0C) m_idx  <= reg_wdata[4:0];
      for (int i = 0; i < 32; i++)
        if (m_lvl[i] && !m_lvld[i]) m_cnt[i] <= m_cnt[i] + 64'd1;
    end
  end

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    case (a)
      5'h00:   return m_mask;
      5'h04:   return m_pend;
      5'h08:   return m_lvl;
      5'h0C:   return {27'h0, m_idx};
      5'h10:   return m_cnt[m_idx][31:0];
      5'h14:   return m_cnt[m_idx][63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00:   return "R7";
      5'h04:   return "R3/R5/R6";
      5'h08:   return "R2";
      5'h10, 5'h14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic observe();
    #1;
    check("R4 cpu_irq", {63'h0, cpu_irq}, {63'h0, m_irq});
    if (!reg_wr_en) check(tag_of(reg_addr), {32'h0, reg_rdata}, {32'h0, exp_read(reg_addr)});
  endtask

  task automatic cyc_read(input logic [4:0] a);
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = a;
    observe();
  endtask

  task automatic cyc_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    observe();
  endtask

  task automatic peek(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = a;
    #1;
    check(req, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    #1;
    check("R1 cpu_irq", {63'h0, cpu_irq}, 64'h0);
    rst_n = 1'b1;
    peek("R1 mask", 5'h00, 32'h0);
    peek("R1 pend", 5'h04, 32'h0);
    peek("R1 lvl",  5'h08, 32'h0);
    peek("R1 cnt",  5'h10, 32'h0);

    // R6: a held request survives its acknowledge
    @(negedge clk); irq_req = 32'h0000_0020;
    repeat (4) cyc_read(5'h04);
    cyc_write(5'h04, 32'h0000_0020);
    peek("R6 held bit still pending", 5'h04, 32'h0000_0020);

    // R5: dropped request clears only acknowledged bits
    @(negedge clk); irq_req = 32'h0000_0080;
    repeat (3) cyc_read(5'h04);
    @(negedge clk); irq_req = 32'h0;
    repeat (4) cyc_read(5'h04);
    cyc_write(5'h04, 32'h0000_0020);
    peek("R5 unacked bit kept", 5'h04, 32'h0000_0080);
    cyc_write(5'h04, 32'hFFFF_FFFF);
    peek("R5 all cleared", 5'h04, 32'h0);

    // R2: level register ignores writes
    cyc_write(5'h08, 32'hFFFF_FFFF);
    peek("R2 level write ignored", 5'h08, 32'h0);

    // R8/R9: counter for input 5 holds one rising edge, high word zero
    cyc_write(5'h0C, 32'h0000_0005);
    peek("R8 count low", 5'h10, 32'h1);
    peek("R9 count high", 5'h14, 32'h0);
    peek("R9 unmapped", 5'h18, 32'h0);

    // R4/R7: mask enables the line
    @(negedge clk); irq_req = 32'h0000_0100;
    cyc_write(5'h00, 32'h0000_0100);
    repeat (4) cyc_read(5'h00);

    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom % 10);
      @(negedge clk);
      reg_wr_en = 1'b0;
      case (op)
        0, 1, 2: irq_req = irq_req ^ (32'h1 << ($urandom % 8));
        3:       irq_req = irq_req ^ (32'h1 << ($urandom % 32));
        4: begin reg_wr_en = 1'b1; reg_addr = 5'h00; reg_wdata = $urandom; end
        5: begin reg_wr_en = 1'b1; reg_addr = 5'h04;
                 reg_wdata = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom; end
        6: begin reg_wr_en = 1'b1; reg_addr = 5'h0C; reg_wdata = $urandom; end
        7: begin reg_wr_en = 1'b1; reg_addr = 5'h08; reg_wdata = $urandom; end
        default: ;
      endcase
      if (!reg_wr_en) reg_addr = 5'(4 * ($urandom % 7));
      observe();
    end

    @(negedge clk); reg_wr_en = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule